// File: doc/BRIEF.md
# Multi-Camera Pixel Stream Integrity Monitor

The block sits between several camera pixel ports and a single downstream buffer. A configuration field picks which camera is live; that camera's pixel valid and pixel data are forwarded with a fixed one-cycle latency. Its frame-start, frame-end, line-start and line-end markers come out as registered single-cycle event pulses. Every other camera port is ignored. A change of the selected camera waits until no frame is open, so a frame never mixes data from two sources.

While forwarding, the block counts the valid pixels of each line and the lines of each frame. It compares them against a programmed width and height. Pixels may arrive with idle cycles between them. A line that closes short of the width, and a frame that closes short of the height, each set a sticky status bit. An enabled status bit drives a level interrupt until software writes a one to clear it. Counting restarts cleanly on the next start marker, so a truncated line or frame does not disturb the checks that follow.

Register map, written through `cfg_we`/`cfg_addr`/`cfg_wdata`:
- 0: width in pixels.
- 1: height in lines.
- 2: control. Bits [1:0] select the camera, bit 4 enables the short-line interrupt, bit 5 enables the short-frame interrupt.
- 3: status, write-one-to-clear. Bit 0 is short line, bit 1 is short frame.

Top module: `cam_stream_monitor`

## Requirements
- R1: One clock after the edge that samples them, `out_valid` and `out_data` equal the valid and data of the active camera; the valid, data and markers of every other camera have no effect on any output.
- R2: `act_cam` takes the value of control bits [1:0] only on an edge at which no frame is open; while a frame is open it holds.
- R3: A start-of-frame, end-of-frame, start-of-line or end-of-line marker on the active camera appears one clock later as a one-cycle pulse on `ev_sof`, `ev_eof`, `ev_sol` or `ev_eol`.
- R4: Inside a line, only cycles with the active valid high and no marker are counted as pixels. Idle cycles between pixels are neither counted nor flagged.
- R5: An end-of-line marker while a line is open with fewer pixels than the width sets status bit 0 (`sts_short_line`).
- R6: A start-of-line, start-of-frame or end-of-frame marker arriving while a line is open with fewer pixels than the width also sets status bit 0.
- R7: An end-of-frame or start-of-frame marker while a frame is open, with fewer lines closed (the open line included) than the height, sets status bit 1 (`sts_short_frame`).
- R8: Status bits are sticky. Writing 1 to a bit of register 3 clears it; writing 0 leaves it. A new error in the same cycle wins over the clear.
- R9: `irq` is high exactly while (bit 0 and enable bit 4) or (bit 1 and enable bit 5).
- R10: After a short line or short frame, the next start marker restarts the pixel or line count from zero, so a following full-length line or frame raises no error.
- R11: During reset, all outputs are low, `act_cam` is 0 and both status bits are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cam_valid | input | NUM_CAMS | Pixel valid per camera |
| cam_sof | input | NUM_CAMS | Start-of-frame marker per camera |
| cam_eof | input | NUM_CAMS | End-of-frame marker per camera |
| cam_sol | input | NUM_CAMS | Start-of-line marker per camera |
| cam_eol | input | NUM_CAMS | End-of-line marker per camera |
| cam_data | input | NUM_CAMS*PIX_W | Pixel data, camera k in slice k |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register index |
| cfg_wdata | input | 32 | Register write data |
| out_valid | output | 1 | Forwarded pixel valid |
| out_data | output | PIX_W | Forwarded pixel data |
| ev_sof | output | 1 | Frame-start event pulse |
| ev_eof | output | 1 | Frame-end event pulse |
| ev_sol | output | 1 | Line-start event pulse |
| ev_eol | output | 1 | Line-end event pulse |
| act_cam | output | SEL_W | Camera currently forwarded |
| sts_short_line | output | 1 | Sticky short-line status |
| sts_short_frame | output | 1 | Sticky short-frame status |
| irq | output | 1 | Level interrupt |

## Verification
Full-length lines with one- and two-cycle gaps between pixels check that idle cycles are not counted as pixels. Lines closed early by an end-of-line marker and lines cut off by a new start-of-line marker are distinct ways a line can close, and each must be flagged. Frames closed early by an end-of-frame marker and frames cut off by a new start-of-frame marker test the frame count in the same way. A full line or frame right after each error shows whether the counters restart cleanly. A neighbouring camera kept busy with pixels and markers shows that inputs are isolated. A selection written mid-frame shows whether the switch waits for the frame boundary.

// File: rtl/cam_mon_pkg.sv
package cam_mon_pkg;
   typedef enum logic [1:0] {
      REG_WIDTH  = 2'd0,
      REG_HEIGHT = 2'd1,
      REG_CTRL   = 2'd2,
      REG_STAT   = 2'd3
   } cfg_reg_e;

   typedef struct packed {
      logic sof;
      logic eof;
      logic sol;
      logic eol;
   } marks_t;

   localparam int CTRL_LINE_EN_BIT  = 4;
   localparam int CTRL_FRAME_EN_BIT = 5;
   localparam int STAT_LINE_BIT     = 0;
   localparam int STAT_FRAME_BIT    = 1;
endpackage

// File: rtl/cam_src_mux.sv
module cam_src_mux
   import cam_mon_pkg::*;
#(
   parameter int NUM_CAMS = 4,
   parameter int PIX_W    = 12,
   parameter int SEL_W    = 2
) (
   input  logic [SEL_W-1:0]          sel,
   input  logic [NUM_CAMS-1:0]       valid_in,
   input  logic [NUM_CAMS-1:0]       sof_in,
   input  logic [NUM_CAMS-1:0]       eof_in,
   input  logic [NUM_CAMS-1:0]       sol_in,
   input  logic [NUM_CAMS-1:0]       eol_in,
   input  logic [NUM_CAMS*PIX_W-1:0] data_in,
   output logic                      valid_out,
   output logic [PIX_W-1:0]          data_out,
   output marks_t                    marks_out
);
   localparam int FULL_DECODE = ((1 << SEL_W) == NUM_CAMS) ? 1 : 0;

   logic [PIX_W-1:0] data_arr [NUM_CAMS];
   logic             sel_ok;

   for (genvar k = 0; k < NUM_CAMS; k++) begin : g_slice
      assign data_arr[k] = data_in[k*PIX_W +: PIX_W];
   end

   if (FULL_DECODE == 1) begin : g_full
      assign sel_ok = 1'b1;
   end else begin : g_part
      assign sel_ok = (32'(sel) < NUM_CAMS);
   end

   always_comb begin
      valid_out = 1'b0;
      data_out  = '0;
      marks_out = '0;
      if (sel_ok) begin
         valid_out     = valid_in[sel];
         data_out      = data_arr[sel];
         marks_out.sof = sof_in[sel];
         marks_out.eof = eof_in[sel];
         marks_out.sol = sol_in[sel];
         marks_out.eol = eol_in[sel];
      end
   end
endmodule

// File: rtl/cam_line_tracker.sv
module cam_line_tracker
   import cam_mon_pkg::*;
#(
   parameter int RES_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pix_valid,
   input  marks_t           marks,
   input  logic [RES_W-1:0] width,
   input  logic [RES_W-1:0] height,
   output logic             short_line_p,
   output logic             short_frame_p,
   output logic             in_frame
);
   localparam logic [RES_W-1:0] CNT_MAX = '1;

   logic             in_frame_q, in_line_q;
   logic [RES_W-1:0] pix_q, lines_q;
   logic [RES_W:0]   lines_total;
   logic             line_short, frame_short;

   assign lines_total = {1'b0, lines_q} + (RES_W+1)'(in_line_q);
   assign line_short  = in_line_q && (pix_q < width);
   assign frame_short = in_frame_q && (lines_total < {1'b0, height});
   assign in_frame    = in_frame_q;

   always_comb begin
      short_line_p  = 1'b0;
      short_frame_p = 1'b0;
      if (marks.sof || marks.eof) begin
         short_line_p  = line_short;
         short_frame_p = frame_short;
      end else if (marks.sol || marks.eol) begin
         short_line_p  = line_short;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_frame_q <= 1'b0;
         in_line_q  <= 1'b0;
         pix_q      <= '0;
         lines_q    <= '0;
      end else if (marks.sof) begin
         in_frame_q <= 1'b1;
         in_line_q  <= 1'b0;
         pix_q      <= '0;
         lines_q    <= '0;
      end else if (marks.eof) begin
         in_frame_q <= 1'b0;
         in_line_q  <= 1'b0;
         pix_q      <= '0;
         lines_q    <= '0;
      end else if (marks.sol) begin
         if (in_line_q && lines_q != CNT_MAX) lines_q <= lines_q + 1'b1;
         in_line_q <= 1'b1;
         pix_q     <= '0;
      end else if (marks.eol) begin
         if (in_line_q && lines_q != CNT_MAX) lines_q <= lines_q + 1'b1;
         in_line_q <= 1'b0;
         pix_q     <= '0;
      end else if (pix_valid && in_line_q && pix_q != CNT_MAX) begin
         pix_q <= pix_q + 1'b1;
      end
   end
endmodule

// File: rtl/cam_cfg_regs.sv
module cam_cfg_regs
   import cam_mon_pkg::*;
#(
   parameter int               RES_W      = 16,
   parameter int               SEL_W      = 2,
   parameter logic [RES_W-1:0] RST_WIDTH  = 16'd1920,
   parameter logic [RES_W-1:0] RST_HEIGHT = 16'd1080
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_addr,
   input  logic [31:0]      cfg_wdata,
   input  logic             short_line_p,
   input  logic             short_frame_p,
   output logic [RES_W-1:0] width,
   output logic [RES_W-1:0] height,
   output logic [SEL_W-1:0] sel_req,
   output logic [1:0]       status,
   output logic             irq
);
   logic [1:0] irq_en;
   logic [1:0] clr, hit;
   logic       wr_stat;

   assign wr_stat = cfg_we && (cfg_reg_e'(cfg_addr) == REG_STAT);
   assign clr     = wr_stat ? {cfg_wdata[STAT_FRAME_BIT], cfg_wdata[STAT_LINE_BIT]} : 2'b00;
   assign hit     = {short_frame_p, short_line_p};
   assign irq     = |(status & irq_en);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         width   <= RST_WIDTH;
         height  <= RST_HEIGHT;
         sel_req <= '0;
         irq_en  <= '0;
      end else if (cfg_we) begin
         case (cfg_reg_e'(cfg_addr))
            REG_WIDTH:  width  <= cfg_wdata[RES_W-1:0];
            REG_HEIGHT: height <= cfg_wdata[RES_W-1:0];
            REG_CTRL: begin
               sel_req <= cfg_wdata[SEL_W-1:0];
               irq_en  <= {cfg_wdata[CTRL_FRAME_EN_BIT], cfg_wdata[CTRL_LINE_EN_BIT]};
            end
            default: ;
         endcase
      end
   end

   for (genvar b = 0; b < 2; b++) begin : g_sticky
      always_ff @(posedge clk) begin
         if (!rst_n) status[b] <= 1'b0;
         else        status[b] <= (status[b] & ~clr[b]) | hit[b];
      end
   end
endmodule

// File: rtl/cam_stream_monitor.sv
module cam_stream_monitor
   import cam_mon_pkg::*;
#(
   parameter int               NUM_CAMS   = 4,
   parameter int               PIX_W      = 12,
   parameter int               RES_W      = 16,
   parameter logic [RES_W-1:0] RST_WIDTH  = 16'd1920,
   parameter logic [RES_W-1:0] RST_HEIGHT = 16'd1080,
   localparam int              SEL_W      = (NUM_CAMS > 1) ? $clog2(NUM_CAMS) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_CAMS-1:0]       cam_valid,
   input  logic [NUM_CAMS-1:0]       cam_sof,
   input  logic [NUM_CAMS-1:0]       cam_eof,
   input  logic [NUM_CAMS-1:0]       cam_sol,
   input  logic [NUM_CAMS-1:0]       cam_eol,
   input  logic [NUM_CAMS*PIX_W-1:0] cam_data,
   input  logic                      cfg_we,
   input  logic [1:0]                cfg_addr,
   input  logic [31:0]               cfg_wdata,
   output logic                      out_valid,
   output logic [PIX_W-1:0]          out_data,
   output logic                      ev_sof,
   output logic                      ev_eof,
   output logic                      ev_sol,
   output logic                      ev_eol,
   output logic [SEL_W-1:0]          act_cam,
   output logic                      sts_short_line,
   output logic                      sts_short_frame,
   output logic                      irq
);
   initial begin
      assert (NUM_CAMS >= 1 && NUM_CAMS <= 16) else $error("NUM_CAMS out of range");
      assert (RES_W >= 2 && RES_W <= 32) else $error("RES_W must be 2..32");
      assert (PIX_W >= 1) else $error("PIX_W must be positive");
   end

   logic             mux_valid;
   logic [PIX_W-1:0] mux_data;
   marks_t           mux_marks;
   logic [RES_W-1:0] width, height;
   logic [SEL_W-1:0] sel_req, act_q;
   logic [1:0]       status;
   logic             short_line_p, short_frame_p, in_frame;

   cam_src_mux #(.NUM_CAMS(NUM_CAMS), .PIX_W(PIX_W), .SEL_W(SEL_W)) u_mux (
      .sel(act_q), .valid_in(cam_valid), .sof_in(cam_sof), .eof_in(cam_eof),
      .sol_in(cam_sol), .eol_in(cam_eol), .data_in(cam_data),
      .valid_out(mux_valid), .data_out(mux_data), .marks_out(mux_marks)
   );

   cam_line_tracker #(.RES_W(RES_W)) u_trk (
      .clk(clk), .rst_n(rst_n), .pix_valid(mux_valid), .marks(mux_marks),
      .width(width), .height(height), .short_line_p(short_line_p),
      .short_frame_p(short_frame_p), .in_frame(in_frame)
   );

   cam_cfg_regs #(.RES_W(RES_W), .SEL_W(SEL_W),
                  .RST_WIDTH(RST_WIDTH), .RST_HEIGHT(RST_HEIGHT)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .short_line_p(short_line_p),
      .short_frame_p(short_frame_p), .width(width), .height(height),
      .sel_req(sel_req), .status(status), .irq(irq)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)         act_q <= '0;
      else if (!in_frame) act_q <= sel_req;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         ev_sof    <= 1'b0;
         ev_eof    <= 1'b0;
         ev_sol    <= 1'b0;
         ev_eol    <= 1'b0;
      end else begin
         out_valid <= mux_valid;
         out_data  <= mux_data;
         ev_sof    <= mux_marks.sof;
         ev_eof    <= mux_marks.eof;
         ev_sol    <= mux_marks.sol;
         ev_eol    <= mux_marks.eol;
      end
   end

   assign act_cam         = act_q;
   assign sts_short_line  = status[STAT_LINE_BIT];
   assign sts_short_frame = status[STAT_FRAME_BIT];
endmodule

// File: rtl/cam_stream_monitor_chk.sv
module cam_stream_monitor_chk #(
   parameter int NUM_CAMS = 4,
   parameter int SEL_W    = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_CAMS-1:0] cam_valid,
   input logic [NUM_CAMS-1:0] cam_sof,
   input logic                cfg_we,
   input logic [1:0]          cfg_addr,
   input logic [31:0]         cfg_wdata,
   input logic                out_valid,
   input logic                ev_sof,
   input logic [SEL_W-1:0]    act_cam,
   input logic                sts_short_line,
   input logic                sts_short_frame,
   input logic                irq,
   input logic                in_frame
);
   p_idle_no_fwd_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(|cam_valid) |=> !out_valid);

   p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_frame |=> $stable(act_cam));

   p_sof_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ev_sof |-> $past(|cam_sof));

   p_line_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_short_line && !(cfg_we && cfg_addr == 2'd3 && cfg_wdata[0])) |=> sts_short_line);

   p_frame_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_short_frame && !(cfg_we && cfg_addr == 2'd3 && cfg_wdata[1])) |=> sts_short_frame);

   p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (sts_short_line || sts_short_frame));
endmodule

bind cam_stream_monitor cam_stream_monitor_chk #(.NUM_CAMS(NUM_CAMS), .SEL_W(SEL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cam_valid(cam_valid), .cam_sof(cam_sof),
   .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
   .out_valid(out_valid), .ev_sof(ev_sof), .act_cam(act_cam),
   .sts_short_line(sts_short_line), .sts_short_frame(sts_short_frame),
   .irq(irq), .in_frame(in_frame)
);

// File: tb/tb_cam_stream_monitor.sv
module tb_cam_stream_monitor;
   localparam int NC = 4;
   localparam int PW = 12;
   localparam int SW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NC-1:0] cv = '0, cfs = '0, cfe = '0, cls = '0, cle = '0;
   logic [NC*PW-1:0] cd = '0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic out_valid, ev_sof, ev_eof, ev_sol, ev_eol, sts_l, sts_f, irq;
   logic [PW-1:0] out_data;
   logic [SW-1:0] act_cam;

   int n_chk = 0, n_fail = 0;
   bit noise_on = 0;
   bit done = 0;

   always #4 clk = ~clk;

   cam_stream_monitor #(.NUM_CAMS(NC), .PIX_W(PW), .RES_W(16)) dut (
      .clk(clk), .rst_n(rst_n), .cam_valid(cv), .cam_sof(cfs), .cam_eof(cfe),
      .cam_sol(cls), .cam_eol(cle), .cam_data(cd), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .out_valid(out_valid),
      .out_data(out_data), .ev_sof(ev_sof), .ev_eof(ev_eof), .ev_sol(ev_sol),
      .ev_eol(ev_eol), .act_cam(act_cam), .sts_short_line(sts_l),
      .sts_short_frame(sts_f), .irq(irq)
   );

   task automatic check(string req, string what, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // behavioural reference model
   int m_w = 1920, m_h = 1080, m_sel = 0, m_act = 0, m_en = 0;
   bit m_infr = 0, m_inln = 0, m_sl = 0, m_sf = 0;
   int m_pix = 0, m_lines = 0;
   bit e_v = 0, e_fs = 0, e_fe = 0, e_ls = 0, e_le = 0;
   int e_d = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_w = 1920; m_h = 1080; m_sel = 0; m_act = 0; m_en = 0;
         m_infr = 0; m_inln = 0; m_sl = 0; m_sf = 0; m_pix = 0; m_lines = 0;
         e_v = 0; e_fs = 0; e_fe = 0; e_ls = 0; e_le = 0; e_d = 0;
      end else begin
         bit v, fs, fe, ls, le, hl, hf, was_fr;
         int a;
         a = m_act; was_fr = m_infr;
         v = cv[a]; fs = cfs[a]; fe = cfe[a]; ls = cls[a]; le = cle[a];
         e_v = v; e_d = int'(cd[a*PW +: PW]);
         e_fs = fs; e_fe = fe; e_ls = ls; e_le = le;
         hl = 0; hf = 0;
         if (fs || fe) begin
            hl = m_inln && (m_pix < m_w);
            hf = m_infr && ((m_lines + (m_inln ? 1 : 0)) < m_h);
            m_infr = fs; m_inln = 0; m_pix = 0; m_lines = 0;
         end else if (ls || le) begin
            if (m_inln) begin
               hl = (m_pix < m_w);
               m_lines++;
            end
            m_inln = ls; m_pix = 0;
         end else if (v && m_inln) begin
            m_pix++;
         end
         if (!was_fr) m_act = m_sel;
         if (cfg_we && cfg_addr == 3) begin
            if (cfg_wdata[0]) m_sl = 0;
            if (cfg_wdata[1]) m_sf = 0;
         end
         if (hl) m_sl = 1;
         if (hf) m_sf = 1;
         if (cfg_we) begin
            case (cfg_addr)
               2'd0: m_w = int'(cfg_wdata[15:0]);
               2'd1: m_h = int'(cfg_wdata[15:0]);
               2'd2: begin m_sel = int'(cfg_wdata[1:0]); m_en = int'(cfg_wdata[5:4]); end
               default: ;
            endcase
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R1", "out_valid", out_valid, e_v);
         if (e_v) check("R1", "out_data", out_data, e_d);
         check("R3", "events", {ev_sof, ev_eof, ev_sol, ev_eol}, {e_fs, e_fe, e_ls, e_le});
         check("R2", "act_cam", act_cam, m_act);
         check("R5", "sts_short_line", sts_l, m_sl);
         check("R7", "sts_short_frame", sts_f, m_sf);
         check("R9", "irq", irq, (m_sl && m_en[0]) || (m_sf && m_en[1]));
      end
   end

   // stimulus
   int cur_cam = 1;
   int cyc = 0;

   task automatic step(bit v, int d, bit [3:0] mk);
      int nz;
      @(negedge clk);
      cyc++;
      cv = '0; cfs = '0; cfe = '0; cls = '0; cle = '0; cd = '0;
      cv[cur_cam] = v;
      cd[cur_cam*PW +: PW] = PW'(d);
      {cfs[cur_cam], cfe[cur_cam], cls[cur_cam], cle[cur_cam]} = mk;
      if (noise_on) begin
         nz = (cur_cam + 1) % NC;
         cv[nz] = 1'b1;
         cd[nz*PW +: PW] = PW'(12'h5A5 ^ cyc);
         {cfs[nz], cfe[nz], cls[nz], cle[nz]} = 4'b1 << (cyc % 4);
      end
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(0, 0, 4'b0000);
   endtask

   task automatic wr(int addr, int data);
      @(negedge clk);
      cv = '0; cfs = '0; cfe = '0; cls = '0; cle = '0;
      cfg_we = 1'b1; cfg_addr = 2'(addr); cfg_wdata = 32'(data);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic line(int npix, bit gaps);
      step(0, 0, 4'b0010);
      for (int i = 0; i < npix; i++) begin
         step(1, 'h100 + i, 4'b0000);
         if (gaps) idle(i % 2 + 1);
      end
      step(0, 0, 4'b0001);
   endtask

   initial begin
      #(8ns * 200000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      check("R11", "outputs in reset", {out_valid, ev_sof, ev_eof, ev_sol, ev_eol, irq}, 0);
      check("R11", "status in reset", {sts_l, sts_f}, 0);
      check("R11", "act_cam in reset", act_cam, 0);
      rst_n = 1'b1;
      wr(0, 4); wr(1, 3); wr(2, 'h31);
      idle(2);
      check("R2", "selection applies between frames", act_cam, 1);
      noise_on = 1;

      // full frame with gaps
      step(0, 0, 4'b1000);
      for (int l = 0; l < 3; l++) line(4, 1);
      step(0, 0, 4'b0100);
      idle(1);
      check("R4", "gappy full frame no line error", sts_l, 0);
      check("R4", "gappy full frame no frame error", sts_f, 0);
      check("R1", "noise camera ignored irq", irq, 0);

      // short line closed by end-of-line
      step(0, 0, 4'b1000);
      line(2, 0);
      idle(1);
      check("R5", "short line flagged", sts_l, 1);
      check("R9", "irq on enabled short line", irq, 1);
      wr(3, 0);
      check("R8", "write 0 keeps status", sts_l, 1);
      wr(3, 1);
      check("R8", "write 1 clears status", sts_l, 0);
      check("R9", "irq drops after clear", irq, 0);

      // line cut off by a new start-of-line
      step(0, 0, 4'b0010);
      step(1, 7, 4'b0000);
      step(0, 0, 4'b0010);
      idle(1);
      check("R6", "line cut by new start flagged", sts_l, 1);
      wr(3, 1);
      for (int i = 0; i < 4; i++) step(1, i, 4'b0000);
      step(0, 0, 4'b0001);
      step(0, 0, 4'b0100);
      idle(1);
      check("R10", "full line after cut no error", sts_l, 0);
      check("R10", "three lines closed frame ok", sts_f, 0);

      // short frame by end-of-frame, then by new start-of-frame
      step(0, 0, 4'b1000);
      line(4, 0);
      step(0, 0, 4'b0100);
      idle(1);
      check("R7", "frame ended early flagged", sts_f, 1);
      wr(3, 2);
      check("R8", "frame status cleared", sts_f, 0);
      step(0, 0, 4'b1000);
      line(4, 1);
      step(0, 0, 4'b1000);
      idle(1);
      check("R7", "frame cut by new start flagged", sts_f, 1);
      wr(3, 2);
      for (int l = 0; l < 3; l++) line(4, 0);
      step(0, 0, 4'b0100);
      idle(1);
      check("R10", "full frame after cut no error", sts_f, 0);

      // selection change inside a frame
      step(0, 0, 4'b1000);
      wr(2, 'h32);
      idle(2);
      check("R2", "selection held mid-frame", act_cam, 1);
      for (int l = 0; l < 3; l++) line(4, 0);
      noise_on = 0;
      step(0, 0, 4'b0100);
      idle(2);
      check("R2", "selection applied after frame end", act_cam, 2);
      cur_cam = 2;

      // new camera, interrupts disabled
      wr(2, 'h02);
      step(0, 0, 4'b1000);
      step(1, 'hABC, 4'b0000);
      idle(1);
      check("R1", "new camera pixel forwarded", out_data, 'hABC);
      step(0, 0, 4'b0010);
      step(1, 1, 4'b0000);
      step(0, 0, 4'b0001);
      idle(1);
      check("R5", "short line on new camera", sts_l, 1);
      check("R9", "irq masked when disabled", irq, 0);
      idle(3);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule